// File: doc/BRIEF.md
# Shift-and-Add Symmetric Six-Tap FIR Filter

This block is a six-tap linear-phase FIR filter with no hardware multipliers. It has a fixed, symmetric set of canonic-signed-digit coefficients. The coefficient pairs are equal: the outer taps share one value, the next pair shares a second, and the two centre taps share a third. Only three distinct products are needed, and a shared shift-and-add network computes them once per sample. That network first forms two partial terms from the input sample: the sample plus a quarter of itself, and the sample minus a quarter of itself. Each product is then built from shifted copies of the sample and of these two terms. A transposed delay chain adds the products into the output. Each product is wired both to its own tap and to its mirror tap.

Both sides of the block use a valid/ready stream. An input sample is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The result for that sample is registered on the same edge and appears on `out_data` with `out_valid` high. It stays there, unchanged, until it is taken by a cycle with `out_ready` high. While a result is held and `out_ready` is low, `in_ready` is low, so no sample is lost and none is overwritten. Values are integers in units of 2^-16 of the input scale. The sum is exact and is neither rounded nor saturated.

Top module: `csd_sym_fir`

## Requirements
- R1: After a synchronous reset, `out_valid` is low and every delay register holds zero. The first results after reset therefore depend only on samples taken after reset.
- R2: Scaled by 2^16, the three coefficient values are 17235 for taps 0 and 5, 12619 for taps 1 and 4, and 14462 for taps 2 and 3.
- R3: Each output equals sum over k=0..5 of c_k·x[n−k], computed exactly in two's complement. Here x[n−k] is the sample taken k accepted samples earlier.
- R4: For a 16-bit sample, the output is 35 bits wide and signed. Full-scale inputs of −32768 and 32767 held on all six taps produce the exact sum without overflow.
- R5: The response to a single non-zero sample followed by zeros lists the six coefficients times that sample, in tap order 0 to 5. This order is symmetric.
- R6: The result for a sample taken on a clock edge is on `out_data` with `out_valid` high right after that same edge.
- R7: The delay registers advance only on an accepted sample. Cycles with `in_valid` low leave the filter history unchanged. If `out_ready` is high in such a cycle, `out_valid` falls after the edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` and `out_valid` hold their values.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 16 | Input sample, signed two's complement |
| out_valid | output | 1 | Filtered result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 35 | Filtered result, signed, units of 2^-16 |

## Verification
A unit impulse reads the coefficient list out in tap order. It separates a wrong shift or sign in any one product from an error in the mirror wiring of the delay chain. A small step shows how the partial sums build up across the chain, so a missing or doubled structural addition stands out. Long runs of full-scale negative and positive samples check that the internal width is enough. Pseudo-random samples, with idle gaps and stalls from the consumer mixed in, are compared with a convolution computed in the bench. This shows that the history moves only on accepted samples and that held results do not change.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;
  // Number of filter taps and distinct coefficient values
  localparam int TAPS      = 6;
  localparam int UNIQ      = TAPS / 2;
  // Fractional bits of the coefficient grid
  localparam int FRAC_BITS = 16;
  // Extra integer bits beyond the sample width: 16 fractional plus sum growth
  localparam int GROW_BITS = 19;
  // Scaled coefficients, used only by the embedded checks
  localparam longint C_OUTER  = 17235;
  localparam longint C_MIDDLE = 12619;
  localparam longint C_CENTRE = 14462;
endpackage

// File: rtl/csd_shared_mult.sv
module csd_shared_mult
  import csd_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = DATA_W + GROW_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] x,
  output logic signed [ACC_W-1:0]  prod [0:UNIQ-1]
);
  logic signed [ACC_W-1:0] xw;
  logic signed [ACC_W-1:0] plus4;   // 4*(x + x/4)
  logic signed [ACC_W-1:0] minus4;  // 4*(x - x/4)

  assign xw     = ACC_W'(x);
  // stage 1: the two shared terms
  assign plus4  = (xw <<< 2) + xw;
  assign minus4 = (xw <<< 2) - xw;

  // outer taps: x/4 + m/64 + p/1024 + m/16384, all on the 2^-16 grid
  assign prod[0] = ((xw <<< 14) + (minus4 <<< 8)) + ((plus4 <<< 4) + minus4);
  // next pair: m/4 + p/256 + m/4096 - x/65536
  assign prod[1] = ((minus4 <<< 12) + (plus4 <<< 6)) + ((minus4 <<< 2) - xw);
  // centre pair: x/4 - x/32 + x/512 - x/32768
  assign prod[2] = ((xw <<< 14) - (xw <<< 11)) + ((xw <<< 7) - (xw <<< 1));

  // R2: each shared product matches its scaled coefficient times the sample
  p_outer_coef_r2: assert property (@(posedge clk) disable iff (rst)
    longint'(prod[0]) == longint'(x) * C_OUTER);
  p_middle_coef_r2: assert property (@(posedge clk) disable iff (rst)
    longint'(prod[1]) == longint'(x) * C_MIDDLE);
  p_centre_coef_r2: assert property (@(posedge clk) disable iff (rst)
    longint'(prod[2]) == longint'(x) * C_CENTRE);
endmodule

// File: rtl/csd_tap_chain.sv
module csd_tap_chain
  import csd_fir_pkg::*;
#(
  parameter int ACC_W = 35
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic signed [ACC_W-1:0] prod [0:UNIQ-1],
  output logic signed [ACC_W-1:0] head
);
  // stage k holds the partial sum for taps k..TAPS-1
  logic signed [ACC_W-1:0] st [1:TAPS-1];

  for (genvar k = 1; k < TAPS; k++) begin : g_stage
    localparam int MIRROR = TAPS - 1 - k;
    localparam int SEL    = (k < MIRROR) ? k : MIRROR;
    logic signed [ACC_W-1:0] nxt;
    if (k == TAPS - 1) begin : g_last
      assign nxt = prod[SEL];
    end else begin : g_mid
      assign nxt = prod[SEL] + st[k+1];
    end
    always_ff @(posedge clk) begin
      if (rst)      st[k] <= '0;
      else if (adv) st[k] <= nxt;
    end
  end

  assign head = st[1];

  // R7: history holds whenever no sample is accepted
  p_hold_history_r7: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(head));
  // R1: the chain is empty in the cycle right after reset
  p_clear_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> head == '0);
endmodule

// File: rtl/csd_sym_fir.sv
module csd_sym_fir
  import csd_fir_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = DATA_W + GROW_BITS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [ACC_W-1:0]  out_data
);
  logic signed [ACC_W-1:0] prod [0:UNIQ-1];
  logic signed [ACC_W-1:0] head;
  logic                    take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  csd_shared_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .clk (clk),
    .rst (rst),
    .x   (in_data),
    .prod(prod)
  );

  csd_tap_chain #(.ACC_W(ACC_W)) u_chain (
    .clk (clk),
    .rst (rst),
    .adv (take),
    .prod(prod),
    .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= prod[0] + head;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled result is held and input is refused
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_stall_block_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  // R6: an accepted sample yields a result right after the edge
  p_result_follows_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  // R9: with no pending result the block is open for input
  p_ready_when_empty_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

// File: tb/csd_sym_fir_test.sv
`timescale 1ns/1ps
module csd_sym_fir_test;
  localparam int DW = 16;
  localparam int AW = DW + 19;
  localparam int NV = 13;
  // stimulus sample and expected result for the table walk (R5 impulse, R3 step)
  localparam longint VEC_X [0:NV-1] = '{1, 0, 0, 0, 0, 0, 0, 2, 2, 2, 2, 2, 2};
  localparam longint VEC_Y [0:NV-1] = '{17235, 12619, 14462, 14462, 12619, 17235, 0,
                                        34470, 59708, 88632, 117556, 142794, 177264};
  localparam longint COEF [0:5] = '{17235, 12619, 14462, 14462, 12619, 17235};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [AW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  longint hist [0:5];
  longint last_exp;
  logic [31:0] lfsr = 32'h1D2C3B4A;

  always #4 clk = ~clk;

  csd_sym_fir #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint conv();
    longint s = 0;
    for (int k = 0; k < 6; k++) s += COEF[k] * hist[k];
    return s;
  endfunction

  task automatic clear_hist();
    for (int k = 0; k < 6; k++) hist[k] = 0;
  endtask

  task automatic accept_model(input longint x);
    for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    last_exp = conv();
  endtask

  // drive one sample with the consumer ready and check the result (R6, R3)
  task automatic push(input longint x, input string req);
    in_valid  = 1'b1;
    in_data   = DW'(x);
    out_ready = 1'b1;
    accept_model(x);
    @(negedge clk);
    check({req, " valid"}, longint'(out_valid), 1);
    check(req, longint'(out_data), last_exp);
  endtask

  task automatic idle(input int n);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R7 valid drops when idle", longint'(out_valid), 0);
    end
  endtask

  function automatic longint next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return longint'($signed(lfsr[15:0]));
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_hist();
    last_exp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R9 in_ready after reset", longint'(in_ready), 1);

    // table walk: impulse (R5) then step (R3)
    for (int i = 0; i < NV; i++) begin
      push(VEC_X[i], "R5/R3 table");
      check("R2 table expected", longint'(out_data), VEC_Y[i]);
    end

    // R7: idle cycles keep the history
    idle(3);
    push(0, "R7 history kept across idle");

    // R4: full scale both signs
    for (int i = 0; i < 6; i++) push(-32768, "R4 negative full scale");
    check("R4 negative sum", longint'(out_data), -32768 * 88632);
    for (int i = 0; i < 6; i++) push(32767, "R4 positive full scale");
    check("R4 positive sum", longint'(out_data), 32767 * 88632);

    // random samples with occasional gaps
    for (int i = 0; i < 60; i++) begin
      push(next_rand(), "R3 random");
      if (i % 13 == 5) idle(2);
    end

    // R8: stall with a pending result
    push(123, "R3 before stall");
    in_valid  = 1'b1;
    in_data   = DW'(777);
    out_ready = 1'b0;
    #1;
    check("R8 in_ready low during stall", longint'(in_ready), 0);
    @(negedge clk);
    check("R8 valid held", longint'(out_valid), 1);
    check("R8 data held", longint'(out_data), last_exp);
    @(negedge clk);
    check("R8 data still held", longint'(out_data), last_exp);
    out_ready = 1'b1;
    #1;
    check("R9 in_ready with consumer ready", longint'(in_ready), 1);
    accept_model(777);
    @(negedge clk);
    check("R8 sample after stall", longint'(out_data), last_exp);
    push(-5, "R3 after stall");

    // R1: reset mid-stream clears the history
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 out_valid after mid reset", longint'(out_valid), 0);
    clear_hist();
    push(5, "R1 first after reset");
    check("R1 only new sample", longint'(out_data), 5 * 17235);
    for (int i = 0; i < 5; i++) push(0, "R1/R5 impulse tail");
    check("R5 last tap", longint'(out_data), 5 * 17235);
    idle(1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule